// File: doc/BRIEF.md
# SMBus Alert Responder

This block is the target-side half of the SMBus alert protocol. While an event is pending and the target is set to interrupt signalling with an active-low event line, it pulls the shared open-drain EVENT wire low. Other targets may pull the same wire, so the line is a wired-AND of all of them. The host then addresses the alert response address with a read. Every alerting target acknowledges and sends its own 7-bit address, and arbitration on SDA leaves one winner. The winner releases EVENT. A loser keeps EVENT low and is served in a later round.

A bit-level protocol engine sits in front of the block. It supplies single-cycle strobes for START, STOP, the SCL rising edge and the SCL falling edge, together with the sampled SDA level. The block returns two pull-down enables, one for SDA and one for EVENT. Decoding of ordinary register accesses to the device address is handled elsewhere.

Top module: `smbus_alert_responder`

## Requirements
- R1: Reset releases the SDA pull-down and clears the "already answered" flag, so a pending event pulls EVENT again after reset.
- R2: `evt_pull` is 1 exactly when `irq_mode`=1, `evt_active_high`=0 and `evt_pending`=1, and the current event has not yet been answered. In all other cases it is 0.
- R3: The first byte after a START is received MSB first. If it equals 8'h19 (alert address 7'b0001100 followed by read bit 1) while `evt_pull`=1 and `resp_en`=1, the block pulls SDA low during the ninth (acknowledge) clock.
- R4: The block never pulls SDA during the address byte. Any other first byte gets no response at all, including 8'h18 (a write to the alert address) and a read of the block's own address.
- R5: With `resp_en`=0 there is no acknowledge and no address response, and EVENT stays pulled.
- R6: After the acknowledge, the block sends the 8-bit word {`own_addr`, 1'b1} MSB first, pulling SDA low for each 0 bit. Each new bit is set up only after an SCL falling strobe.
- R7: If the block releases SDA for a 1 and samples SDA low at the SCL rising strobe, it has lost arbitration. It then stops driving SDA until the next START or STOP, and EVENT stays pulled.
- R8: If all 8 response bits are sent without a loss, EVENT is released. It stays released, and further alert reads get no acknowledge, until `evt_pending` drops to 0 and rises again.
- R9: A STOP or START strobe in any phase releases SDA on the next cycle and leaves EVENT unchanged.
- R10: A repeated START during an address byte restarts reception, so a following alert read is answered normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_start | input | 1 | One-cycle strobe: START or repeated START seen |
| bus_stop | input | 1 | One-cycle strobe: STOP seen |
| scl_rise | input | 1 | One-cycle strobe: SCL rising edge, sample SDA |
| scl_fall | input | 1 | One-cycle strobe: SCL falling edge, SDA may change |
| sda_in | input | 1 | Sampled SDA line level |
| own_addr | input | ADDR_W | The device's 7-bit address |
| irq_mode | input | 1 | 1 = event output in interrupt mode |
| evt_active_high | input | 1 | Event polarity, 0 = active low (required for alerting) |
| resp_en | input | 1 | 1 = alert response enabled |
| evt_pending | input | 1 | An event awaits service |
| sda_pull | output | 1 | 1 = pull SDA low |
| evt_pull | output | 1 | 1 = pull EVENT low |

## Verification
The checker watches four behaviours on every cycle: EVENT is pulled only under the mode, polarity and pending gate; a new SDA pull starts only after an SCL falling strobe; SDA is free the cycle after any START or STOP; and EVENT falls by itself only two cycles after an SCL rising strobe, which is the moment of a win. The bench scenarios cover the rest: which first bytes are answered, the exact bit pattern of the address response, dropping out at the right bit when a competing target pulls SDA, the re-arm after a win, and recovery after aborted or restarted transfers.

// File: rtl/smbus_alert_pkg.sv
// Package: shared constants and state type for the SMBus alert responder.
// Assumes a 7-bit target address space.
package smbus_alert_pkg;

    // Transmit-side phases of one alert response.
    typedef enum logic [2:0] {
        TX_IDLE,      // waiting for a matching alert read
        TX_ACK_WAIT,  // matched; waiting for SCL low to assert ACK
        TX_ACK_DRIVE, // ACK on SDA; waiting for host to sample it
        TX_ACK_END,   // ACK sampled; waiting for SCL low to send bit 0
        TX_DATA,      // sending the address word with arbitration
        TX_TAIL,      // word sent; release SDA on next SCL low
        TX_HOLD       // finished or lost; silent until START/STOP
    } tx_state_t;

    // Default alert response address (7 bits).
    localparam logic [6:0] ALERT_ADDR_DEF = 7'b0001100;

endpackage

// File: rtl/smbus_alert_addr_rx.sv
// Receives the first byte after a START, MSB first, one bit per SCL rising
// strobe. Signals completion with a one-cycle pulse, with the byte held
// stable afterwards. Assumes strobes are single-cycle and mutually spaced.
module smbus_alert_addr_rx #(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              scl_rise,
    input  logic              sda_in,
    output logic              byte_done,
    output logic [ADDR_W:0]   byte_val
);
    localparam int BYTE_W = ADDR_W + 1;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    logic              active_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] shift_q;
    logic              done_q;

    // Shift in the address byte and flag its completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            shift_q  <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (bus_start) begin
                active_q <= 1'b1;
                cnt_q    <= '0;
            end else if (bus_stop) begin
                active_q <= 1'b0;
            end else if (active_q && scl_rise) begin
                shift_q <= {shift_q[BYTE_W-2:0], sda_in};
                cnt_q   <= cnt_q + 1'b1;
                if (cnt_q == CNT_W'(BYTE_W - 1)) begin
                    active_q <= 1'b0;
                    done_q   <= 1'b1;
                end
            end
        end
    end

    assign byte_done = done_q;
    assign byte_val  = shift_q;
endmodule

// File: rtl/smbus_alert_evt_ctrl.sv
// Drives the EVENT pull-down. Holds an "answered" flag set by an
// arbitration win and cleared once the pending event goes away.
// Assumes evt_pending is synchronous to clk.
module smbus_alert_evt_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_mode,
    input  logic evt_active_high,
    input  logic evt_pending,
    input  logic won,
    output logic evt_pull
);
    logic answered_q;

    // Remember a won response until the event source clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            answered_q <= 1'b0;
        end else if (!evt_pending) begin
            answered_q <= 1'b0;
        end else if (won) begin
            answered_q <= 1'b1;
        end
    end

    // EVENT pulled only in active-low interrupt signalling.
    always_comb begin
        evt_pull = irq_mode && !evt_active_high && evt_pending && !answered_q;
    end
endmodule

// File: rtl/smbus_alert_resp_tx.sv
// Sends ACK and then the word {own_addr, 1} MSB first, arbitrating on SDA.
// A bit changes only after an SCL falling strobe. A loss is seen at the SCL
// rising strobe and silences the block until START/STOP.
// Assumes the falling strobe comes at least two cycles after the match pulse.
module smbus_alert_resp_tx
    import smbus_alert_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_in,
    input  logic              hit,
    input  logic [ADDR_W-1:0] own_addr,
    output logic              sda_pull,
    output logic              won
);
    localparam int BYTE_W = ADDR_W + 1;
    localparam int IDX_W  = $clog2(BYTE_W + 1);

    tx_state_t         state_q;
    logic [BYTE_W-1:0] word_q;
    logic [IDX_W-1:0]  sent_q;
    logic              drive_q;
    logic              won_q;

    // Response sequencer with bitwise arbitration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            word_q  <= '0;
            sent_q  <= '0;
            drive_q <= 1'b0;
            won_q   <= 1'b0;
        end else begin
            won_q <= 1'b0;
            if (bus_start || bus_stop) begin
                state_q <= TX_IDLE;
                drive_q <= 1'b0;
            end else begin
                unique case (state_q)
                    TX_IDLE: begin
                        drive_q <= 1'b0;
                        if (hit) begin
                            word_q  <= {own_addr, 1'b1};
                            state_q <= TX_ACK_WAIT;
                        end
                    end
                    TX_ACK_WAIT: begin
                        if (scl_fall) begin
                            drive_q <= 1'b1;
                            state_q <= TX_ACK_DRIVE;
                        end
                    end
                    TX_ACK_DRIVE: begin
                        if (scl_rise) begin
                            state_q <= TX_ACK_END;
                        end
                    end
                    TX_ACK_END: begin
                        if (scl_fall) begin
                            drive_q <= !word_q[BYTE_W-1];
                            word_q  <= word_q << 1;
                            sent_q  <= IDX_W'(1);
                            state_q <= TX_DATA;
                        end
                    end
                    TX_DATA: begin
                        if (scl_rise) begin
                            if (!drive_q && !sda_in) begin
                                state_q <= TX_HOLD;
                            end else if (sent_q == IDX_W'(BYTE_W)) begin
                                won_q   <= 1'b1;
                                state_q <= TX_TAIL;
                            end
                        end else if (scl_fall) begin
                            drive_q <= !word_q[BYTE_W-1];
                            word_q  <= word_q << 1;
                            sent_q  <= sent_q + 1'b1;
                        end
                    end
                    TX_TAIL: begin
                        if (scl_fall) begin
                            drive_q <= 1'b0;
                            state_q <= TX_HOLD;
                        end
                    end
                    TX_HOLD: begin
                        drive_q <= 1'b0;
                    end
                    default: begin
                        state_q <= TX_IDLE;
                        drive_q <= 1'b0;
                    end
                endcase
            end
        end
    end

    assign sda_pull = drive_q;
    assign won      = won_q;
endmodule

// File: rtl/smbus_alert_responder.sv
// Top: target side of the SMBus alert exchange. Pulls EVENT while an event is
// pending in active-low interrupt signalling. Answers an alert read with its
// own address under SDA arbitration, and releases EVENT only after a win.
// Assumes bit strobes come from a separate protocol engine.
module smbus_alert_responder
    import smbus_alert_pkg::*;
#(
    parameter int              ADDR_W     = 7,
    parameter logic [ADDR_W-1:0] ALERT_ADDR = ALERT_ADDR_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_in,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              irq_mode,
    input  logic              evt_active_high,
    input  logic              resp_en,
    input  logic              evt_pending,
    output logic              sda_pull,
    output logic              evt_pull
);
    localparam logic [ADDR_W:0] ALERT_READ = {ALERT_ADDR, 1'b1};

    logic            byte_done;
    logic [ADDR_W:0] byte_val;
    logic            hit;
    logic            won;

    smbus_alert_addr_rx #(.ADDR_W(ADDR_W)) rx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_start (bus_start),
        .bus_stop  (bus_stop),
        .scl_rise  (scl_rise),
        .sda_in    (sda_in),
        .byte_done (byte_done),
        .byte_val  (byte_val)
    );

    // Answer only a read of the alert address while alerting and enabled.
    always_comb begin
        hit = byte_done && (byte_val == ALERT_READ) && evt_pull && resp_en;
    end

    smbus_alert_resp_tx #(.ADDR_W(ADDR_W)) tx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_start (bus_start),
        .bus_stop  (bus_stop),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_in    (sda_in),
        .hit       (hit),
        .own_addr  (own_addr),
        .sda_pull  (sda_pull),
        .won       (won)
    );

    smbus_alert_evt_ctrl evt_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .irq_mode        (irq_mode),
        .evt_active_high (evt_active_high),
        .evt_pending     (evt_pending),
        .won             (won),
        .evt_pull        (evt_pull)
    );
endmodule

// File: rtl/smbus_alert_responder_chk.sv
// Checker: cycle-level properties of the alert responder's ports.
// Assumes it is bound into smbus_alert_responder.
module smbus_alert_responder_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_start,
    input logic bus_stop,
    input logic scl_rise,
    input logic scl_fall,
    input logic irq_mode,
    input logic evt_active_high,
    input logic evt_pending,
    input logic sda_pull,
    input logic evt_pull
);
    // EVENT pulled only under the mode/polarity/pending gate.
    assert_evt_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        evt_pull |-> (irq_mode && !evt_active_high && evt_pending));

    // A new SDA pull starts only after an SCL falling strobe.
    assert_drive_after_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> $past(scl_fall));

    // START or STOP frees SDA on the next cycle.
    assert_abort_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_start || bus_stop) |=> !sda_pull);

    // With inputs steady, EVENT falls only two cycles after an SCL rise (a win).
    assert_evt_release_on_win_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(evt_pull) && $stable(evt_pending) && $stable(irq_mode)
         && $stable(evt_active_high)) |-> $past(scl_rise, 2));
endmodule

bind smbus_alert_responder smbus_alert_responder_chk chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .bus_start       (bus_start),
    .bus_stop        (bus_stop),
    .scl_rise        (scl_rise),
    .scl_fall        (scl_fall),
    .irq_mode        (irq_mode),
    .evt_active_high (evt_active_high),
    .evt_pending     (evt_pending),
    .sda_pull        (sda_pull),
    .evt_pull        (evt_pull)
);

// File: tb/smbus_alert_responder_tb_top.sv
`timescale 1ns/1ps
// Bench: walks a vector table of alert transactions, then runs directed tests.
module smbus_alert_responder_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_start = 1'b0, bus_stop = 1'b0, scl_rise = 1'b0, scl_fall = 1'b0;
    logic       sda_in;
    logic [6:0] own_addr = 7'h4A;
    logic       irq_mode = 1'b1, evt_active_high = 1'b0, resp_en = 1'b1, evt_pending = 1'b0;
    logic       sda_pull, evt_pull;
    logic       host_pd = 1'b0, comp_pd = 1'b0;
    int         n_chk = 0, n_fail = 0;

    always #10 clk = ~clk; // 50 MHz

    // Wired-AND SDA: anyone pulling wins.
    assign sda_in = ~(sda_pull | host_pd | comp_pd);

    smbus_alert_responder dut_i (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_in(sda_in),
        .own_addr(own_addr), .irq_mode(irq_mode), .evt_active_high(evt_active_high),
        .resp_en(resp_en), .evt_pending(evt_pending),
        .sda_pull(sda_pull), .evt_pull(evt_pull)
    );

    typedef struct packed {
        logic [6:0] dev;
        logic [7:0] abyte;
        logic       en;
        logic       intr;
        logic       pol;
        logic [7:0] comp;    // competing target's word, 8'hFF = none
        logic       exp_ack;
        logic       exp_win;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{7'h4A, 8'h19, 1'b1, 1'b1, 1'b0, 8'hFF, 1'b1, 1'b1}, // R3 R6 R8 alone
        '{7'h4A, 8'h18, 1'b1, 1'b1, 1'b0, 8'hFF, 1'b0, 1'b0}, // R4 write to alert addr
        '{7'h4A, 8'h19, 1'b0, 1'b1, 1'b0, 8'hFF, 1'b0, 1'b0}, // R5 response disabled
        '{7'h4A, 8'h19, 1'b1, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0}, // R2 not interrupt mode
        '{7'h4A, 8'h19, 1'b1, 1'b1, 1'b1, 8'hFF, 1'b0, 1'b0}, // R2 active-high polarity
        '{7'h4A, 8'h19, 1'b1, 1'b1, 1'b0, 8'h85, 1'b1, 1'b0}, // R7 lose at 4th bit
        '{7'h30, 8'h19, 1'b1, 1'b1, 1'b0, 8'hE1, 1'b1, 1'b1}, // R7 competitor loses
        '{7'h4A, 8'h95, 1'b1, 1'b1, 1'b0, 8'hFF, 1'b0, 1'b0}  // R4 own address read
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_start();
        @(negedge clk) bus_start = 1'b1;
        @(negedge clk) bus_start = 1'b0; host_pd = 1'b0; comp_pd = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic do_stop();
        @(negedge clk) bus_stop = 1'b1; host_pd = 1'b0; comp_pd = 1'b0;
        @(negedge clk) bus_stop = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // One SCL period: fall, set drivers, rise (sample DUT drive there).
    task automatic send_bit(input logic hlow, input logic clow, output logic drv);
        @(negedge clk) scl_fall = 1'b1;
        @(negedge clk) scl_fall = 1'b0;
        repeat (2) @(negedge clk);
        host_pd = hlow; comp_pd = clow;
        @(negedge clk) scl_rise = 1'b1; drv = sda_pull;
        @(negedge clk) scl_rise = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] abyte, input logic [7:0] comp,
                        output logic addr_any, output logic ack, output logic [7:0] resp);
        logic d;
        addr_any = 1'b0;
        do_start();
        for (int i = 7; i >= 0; i--) begin
            send_bit(!abyte[i], 1'b0, d);
            addr_any |= d;
        end
        send_bit(1'b0, 1'b0, ack);
        for (int i = 7; i >= 0; i--) begin
            send_bit(1'b0, !comp[i], d);
            resp[i] = d;
        end
        send_bit(1'b0, 1'b0, d); // host NACK
        do_stop();
    endtask

    // Expected SDA pulls of the response word under arbitration.
    function automatic logic [7:0] model_resp(input logic [6:0] dev, input logic [7:0] comp,
                                              input logic respond);
        logic [7:0] w = {dev, 1'b1};
        logic [7:0] r = '0;
        logic lost = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            if (respond && !lost) begin
                r[i] = !w[i];
                if (w[i] && !comp[i]) lost = 1'b1;
            end
        end
        return r;
    endfunction

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic any, ack, d;
        logic [7:0] resp;
        // R1: reset state
        evt_pending = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 sda_pull in reset", sda_pull, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 sda_pull after reset", sda_pull, 0);
        check("R1 evt_pull idle", evt_pull, 0);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            own_addr = VECS[v].dev; resp_en = VECS[v].en;
            irq_mode = VECS[v].intr; evt_active_high = VECS[v].pol;
            evt_pending = 1'b0;
            repeat (3) @(negedge clk);
            evt_pending = 1'b1;
            repeat (3) @(negedge clk);
            check("R2 evt_pull gate", evt_pull, VECS[v].intr && !VECS[v].pol);
            xfer(VECS[v].abyte, VECS[v].comp, any, ack, resp);
            check("R4 no pull in address byte", any, 0);
            check("R3 ack", ack, VECS[v].exp_ack);
            check("R6 R7 response bits", resp, model_resp(VECS[v].dev, VECS[v].comp, VECS[v].exp_ack));
            check("R8 R7 evt after", evt_pull, VECS[v].intr && !VECS[v].pol && !VECS[v].exp_win);
        end

        // R8: answered event not re-served until pending re-arms
        own_addr = 7'h4A; resp_en = 1'b1; irq_mode = 1'b1; evt_active_high = 1'b0;
        evt_pending = 1'b0; repeat (3) @(negedge clk);
        evt_pending = 1'b1; repeat (3) @(negedge clk);
        xfer(8'h19, 8'hFF, any, ack, resp);
        check("R8 first read wins", evt_pull, 0);
        xfer(8'h19, 8'hFF, any, ack, resp);
        check("R8 second read no ack", ack, 0);
        check("R8 evt stays released", evt_pull, 0);
        // R1: reset clears the answered flag
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 answered flag cleared", evt_pull, 1);
        evt_pending = 1'b0; @(negedge clk);
        check("R8 pending low", evt_pull, 0);
        evt_pending = 1'b1; @(negedge clk);
        check("R8 re-armed", evt_pull, 1);

        // R9: STOP during address byte
        do_start();
        for (int i = 7; i >= 4; i--) send_bit(!(8'h19 >> i & 1), 1'b0, d);
        do_stop();
        check("R9 no pull after early stop", sda_pull, 0);
        check("R9 evt kept", evt_pull, 1);
        // R9: STOP during response while driving
        do_start();
        for (int i = 7; i >= 0; i--) send_bit(!(8'h19 >> i & 1), 1'b0, d);
        send_bit(1'b0, 1'b0, ack);
        check("R3 ack before abort", ack, 1);
        for (int i = 0; i < 3; i++) send_bit(1'b0, 1'b0, d);
        check("R6 driving third bit", d, 1);
        @(negedge clk) bus_stop = 1'b1;
        @(negedge clk) bus_stop = 1'b0;
        check("R9 released after stop", sda_pull, 0);
        check("R9 evt unchanged", evt_pull, 1);
        repeat (2) @(negedge clk);

        // R10: repeated START mid address byte
        do_start();
        for (int i = 0; i < 3; i++) send_bit(i[0], 1'b0, d);
        xfer(8'h19, 8'hFF, any, ack, resp);
        check("R10 ack after restart", ack, 1);
        check("R10 response", resp, 8'h6A);
        check("R8 released after restart win", evt_pull, 0);

        // R5: disable then re-enable response
        evt_pending = 1'b0; repeat (2) @(negedge clk);
        evt_pending = 1'b1; resp_en = 1'b0; repeat (2) @(negedge clk);
        xfer(8'h19, 8'hFF, any, ack, resp);
        check("R5 no ack disabled", ack, 0);
        check("R5 evt held", evt_pull, 1);
        resp_en = 1'b1;
        xfer(8'h19, 8'hFF, any, ack, resp);
        check("R5 ack re-enabled", ack, 1);

        finish_run();
    end
endmodule